// File: doc/BRIEF.md
# Horizontal Eye Width Scan Controller

This block measures the horizontal opening of a receiver eye. It moves the sampling-phase code sent to a phase interpolator one step at a time across a programmed range. After each move it waits for the sampling point to settle. It then checks a fixed number of deserialized data words against a locally generated PRBS-7 pattern.

A phase step passes only if every checked word matches the pattern. The number of passing steps is the horizontal eye width. When no step passes, the block reports a width of zero and raises an eye-closed flag.

A scan begins with a one-cycle start pulse. The step range and the dwell length are captured at that moment. The phase code is driven straight to the interpolator. Sampled words arrive on a data bus qualified by a valid bit. When the sweep ends the block gives a one-cycle done pulse, and the result outputs then hold steady until the next scan begins.

Top module: `eye_scan_ctrl`

## Requirements
- R1: After reset, busy, done and eye_closed are 0, eye_width is 0 and phase_code is 0.
- R2: A start pulse while idle captures first_code, last_code and dwell_words. phase_code is set to first_code and rises by exactly 1 after each step, and the scan ends after the step at last_code. If last_code is not above first_code, only the step at first_code is measured. phase_code does not change while the block is idle.
- R3: After each load or change of phase_code, the next SETTLE_CYC clock cycles are settle time, and words arriving in them (valid or not) are ignored.
- R4: The first valid word after settle time seeds the checker. Bit 0 of every word is the earliest bit in time. The seed is bits [DATA_W-1:DATA_W-7] of that word. Each later bit is predicted as b[n] = b[n-7] XOR b[n-6] (polynomial x^7+x^6+1), continuing from the locally generated history.
- R5: After the seed word, exactly dwell_words valid words are compared, with a dwell_words value of 0 treated as 1. Cycles with rx_valid low are skipped. A step counts as passing only if none of its compared words differs from the prediction in any bit.
- R6: With rx_valid held high, each step takes SETTLE_CYC + dwell + 2 cycles. done is a one-cycle pulse, raised with busy low, in the cycle after the last step is evaluated.
- R7: eye_width equals the number of passing steps and can reach 2^PHASE_W. eye_closed is 1 exactly when that count is 0. Both are cleared by start and then hold their values from done until the next start.
- R8: A start pulse while busy is ignored, and so are changes to the configuration inputs: the result and the scan length stay those of the running scan.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle scan request |
| first_code | input | PHASE_W | First phase code of the sweep |
| last_code | input | PHASE_W | Last phase code of the sweep |
| dwell_words | input | DWELL_W | Words compared per step (0 acts as 1) |
| rx_data | input | DATA_W | Deserialized sampled word, bit 0 earliest |
| rx_valid | input | 1 | rx_data qualifier |
| phase_code | output | PHASE_W | Sampling-phase code to the interpolator |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| eye_width | output | PHASE_W+1 | Count of error-free steps |
| eye_closed | output | 1 | No step was error-free |

## Verification
The bench targets several corner cases, each paired with the wrong result a faulty design would give:
- A single flipped bit in the second compared word of one step inside the eye: a design that missed it, or kept the step passing, would report a width one too large.
- Corrupted words during settle time: a design that seeded or compared too early would lose steps.
- Starts that are then ignored, and configuration changes in the middle of a scan: a design that restarted or failed to latch its settings would give a wrong scan length or width.
- A dwell of zero, a reversed range, a full 32-step open range that needs the extra result bit, and a fully closed eye: these would expose wrong cycle counts, a truncated width or a missing closed flag.
- Gaps in rx_valid: a design that counted idle cycles as words would fail here.

// File: rtl/eye_scan_pkg.sv
package eye_scan_pkg;

    localparam int PRBS_LEN = 7;

    typedef logic [PRBS_LEN-1:0] prbs_hist_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_SEED,
        ST_CHECK,
        ST_EVAL
    } scan_state_e;

    // hist[0] is the oldest bit (n-7), hist[6] the newest (n-1)
    function automatic prbs_hist_t prbs7_advance(prbs_hist_t h);
        return {h[0] ^ h[1], h[PRBS_LEN-1:1]};
    endfunction

endpackage

// File: rtl/eye_scan_prbs.sv
module eye_scan_prbs
    import eye_scan_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              seed_en,
    input  logic              chk_en,
    input  logic [DATA_W-1:0] rx_data,
    output logic              word_bad
);

    prbs_hist_t        hist_q;
    prbs_hist_t        hist_nx;
    logic [DATA_W-1:0] pred;

    always_comb begin
        hist_nx = hist_q;
        pred    = '0;
        for (int i = 0; i < DATA_W; i++) begin
            hist_nx = prbs7_advance(hist_nx);
            pred[i] = hist_nx[PRBS_LEN-1];
        end
    end

    assign word_bad = (pred != rx_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else if (seed_en) begin
            hist_q <= rx_data[DATA_W-1 -: PRBS_LEN];
        end else if (chk_en) begin
            hist_q <= hist_nx;
        end
    end

endmodule

// File: rtl/eye_scan_seq.sv
module eye_scan_seq
    import eye_scan_pkg::*;
#(
    parameter int PHASE_W    = 5,
    parameter int DWELL_W    = 8,
    parameter int SETTLE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PHASE_W-1:0] first_code,
    input  logic [PHASE_W-1:0] last_code,
    input  logic [DWELL_W-1:0] dwell_words,
    input  logic               rx_valid,
    input  logic               word_bad,
    output logic [PHASE_W-1:0] phase_code,
    output logic               busy,
    output logic               scan_begin,
    output logic               seed_en,
    output logic               chk_en,
    output logic               eval_en,
    output logic               step_ok,
    output logic               scan_end
);

    localparam int SET_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
    localparam logic [SET_W-1:0] SET_LAST = SET_W'(SETTLE_CYC - 1);

    scan_state_e        state_q;
    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] last_q;
    logic [DWELL_W-1:0] dwell_q;
    logic [DWELL_W-1:0] word_cnt;
    logic [SET_W-1:0]   settle_cnt;
    logic               err_q;

    assign phase_code = phase_q;
    assign busy       = (state_q != ST_IDLE);
    assign scan_begin = (state_q == ST_IDLE) && start;
    assign seed_en    = (state_q == ST_SEED) && rx_valid;
    assign chk_en     = (state_q == ST_CHECK) && rx_valid;
    assign eval_en    = (state_q == ST_EVAL);
    assign step_ok    = !err_q;
    assign scan_end   = eval_en && (phase_q >= last_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            phase_q    <= '0;
            last_q     <= '0;
            dwell_q    <= DWELL_W'(1);
            word_cnt   <= '0;
            settle_cnt <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        phase_q    <= first_code;
                        last_q     <= last_code;
                        dwell_q    <= (dwell_words == '0) ? DWELL_W'(1) : dwell_words;
                        settle_cnt <= '0;
                        state_q    <= ST_SETTLE;
                    end
                end
                ST_SETTLE: begin
                    if (settle_cnt == SET_LAST) begin
                        settle_cnt <= '0;
                        state_q    <= ST_SEED;
                    end else begin
                        settle_cnt <= settle_cnt + 1'b1;
                    end
                end
                ST_SEED: begin
                    if (rx_valid) begin
                        word_cnt <= '0;
                        err_q    <= 1'b0;
                        state_q  <= ST_CHECK;
                    end
                end
                ST_CHECK: begin
                    if (rx_valid) begin
                        err_q <= err_q | word_bad;
                        if (word_cnt == dwell_q - 1'b1) begin
                            state_q <= ST_EVAL;
                        end else begin
                            word_cnt <= word_cnt + 1'b1;
                        end
                    end
                end
                ST_EVAL: begin
                    if (phase_q >= last_q) begin
                        state_q <= ST_IDLE;
                    end else begin
                        phase_q    <= phase_q + 1'b1;
                        settle_cnt <= '0;
                        state_q    <= ST_SETTLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/eye_scan_tally.sv
module eye_scan_tally #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scan_begin,
    input  logic             eval_en,
    input  logic             step_ok,
    input  logic             scan_end,
    output logic [CNT_W-1:0] eye_width,
    output logic             eye_closed,
    output logic             done
);

    logic [CNT_W-1:0] width_nx;

    assign width_nx = eye_width + (step_ok ? CNT_W'(1) : CNT_W'(0));

    always_ff @(posedge clk) begin
        if (rst) begin
            eye_width  <= '0;
            eye_closed <= 1'b0;
            done       <= 1'b0;
        end else begin
            done <= 1'b0;
            if (scan_begin) begin
                eye_width  <= '0;
                eye_closed <= 1'b0;
            end else if (eval_en) begin
                eye_width <= width_nx;
                if (scan_end) begin
                    done       <= 1'b1;
                    eye_closed <= (width_nx == '0);
                end
            end
        end
    end

endmodule

// File: rtl/eye_scan_ctrl.sv
module eye_scan_ctrl #(
    parameter int DATA_W     = 8,
    parameter int PHASE_W    = 5,
    parameter int DWELL_W    = 8,
    parameter int SETTLE_CYC = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [PHASE_W-1:0] first_code,
    input  logic [PHASE_W-1:0] last_code,
    input  logic [DWELL_W-1:0] dwell_words,
    input  logic [DATA_W-1:0]  rx_data,
    input  logic               rx_valid,
    output logic [PHASE_W-1:0] phase_code,
    output logic               busy,
    output logic               done,
    output logic [PHASE_W:0]   eye_width,
    output logic               eye_closed
);

    localparam int CNT_W = PHASE_W + 1;

    logic scan_begin;
    logic seed_en;
    logic chk_en;
    logic eval_en;
    logic step_ok;
    logic scan_end;
    logic word_bad;

    eye_scan_seq #(
        .PHASE_W   (PHASE_W),
        .DWELL_W   (DWELL_W),
        .SETTLE_CYC(SETTLE_CYC)
    ) i_seq (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .first_code (first_code),
        .last_code  (last_code),
        .dwell_words(dwell_words),
        .rx_valid   (rx_valid),
        .word_bad   (word_bad),
        .phase_code (phase_code),
        .busy       (busy),
        .scan_begin (scan_begin),
        .seed_en    (seed_en),
        .chk_en     (chk_en),
        .eval_en    (eval_en),
        .step_ok    (step_ok),
        .scan_end   (scan_end)
    );

    eye_scan_prbs #(
        .DATA_W(DATA_W)
    ) i_prbs (
        .clk     (clk),
        .rst     (rst),
        .seed_en (seed_en),
        .chk_en  (chk_en),
        .rx_data (rx_data),
        .word_bad(word_bad)
    );

    eye_scan_tally #(
        .CNT_W(CNT_W)
    ) i_tally (
        .clk       (clk),
        .rst       (rst),
        .scan_begin(scan_begin),
        .eval_en   (eval_en),
        .step_ok   (step_ok),
        .scan_end  (scan_end),
        .eye_width (eye_width),
        .eye_closed(eye_closed),
        .done      (done)
    );

endmodule

// File: rtl/eye_scan_ctrl_chk.sv
module eye_scan_ctrl_chk #(
    parameter int PHASE_W = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [PHASE_W-1:0] phase_code,
    input logic               busy,
    input logic               done,
    input logic [PHASE_W:0]   eye_width,
    input logic               eye_closed
);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7
    closed_zero_chk: assert property (@(posedge clk) disable iff (rst)
        eye_closed |-> (eye_width == '0));

    // R7
    result_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(eye_width) && $stable(eye_closed)));

    // R2
    phase_step_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy && !$stable(phase_code))
            |-> (phase_code == $past(phase_code) + 1'b1));

    // R2
    phase_idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> $stable(phase_code));

endmodule

bind eye_scan_ctrl eye_scan_ctrl_chk #(.PHASE_W(PHASE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .phase_code(phase_code),
    .busy      (busy),
    .done      (done),
    .eye_width (eye_width),
    .eye_closed(eye_closed)
);

// File: tb/test_eye_scan_ctrl.sv
`timescale 1ns/1ps
module test_eye_scan_ctrl;

    localparam int DATA_W  = 8;
    localparam int PHASE_W = 5;
    localparam int DWELL_W = 8;
    localparam int SETTLE  = 3;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               start = 1'b0;
    logic [PHASE_W-1:0] first_code = '0;
    logic [PHASE_W-1:0] last_code = '0;
    logic [DWELL_W-1:0] dwell_words = '0;
    logic [DATA_W-1:0]  rx_data = '0;
    logic               rx_valid = 1'b0;
    logic [PHASE_W-1:0] phase_code;
    logic               busy;
    logic               done;
    logic [PHASE_W:0]   eye_width;
    logic               eye_closed;

    int checks = 0;
    int errors = 0;
    longint cyc = 0;

    // stimulus controls
    int  good_lo = 0, good_hi = -1;
    bit  hit_en = 0;
    int  hit_ph = 0;
    bit  noise_en = 0;
    bit  gap_en = 0;
    bit  monitor_on = 0;
    int  cfg_first = 0, cfg_last = 0;
    int  widx = 0;
    int  prev_phase = -1;
    bit  start_seen = 0;
    bit  sq[$];

    eye_scan_ctrl #(
        .DATA_W(DATA_W), .PHASE_W(PHASE_W), .DWELL_W(DWELL_W), .SETTLE_CYC(SETTLE)
    ) i_eye_scan_ctrl (
        .clk(clk), .rst(rst), .start(start), .first_code(first_code),
        .last_code(last_code), .dwell_words(dwell_words), .rx_data(rx_data),
        .rx_valid(rx_valid), .phase_code(phase_code), .busy(busy), .done(done),
        .eye_width(eye_width), .eye_closed(eye_closed)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // bit-serial PRBS-7 source, earliest bit placed in word bit 0
    function automatic logic [DATA_W-1:0] next_word();
        logic [DATA_W-1:0] w;
        for (int i = 0; i < DATA_W; i++) begin
            bit nb;
            nb = sq[sq.size()-7] ^ sq[sq.size()-6];
            sq.push_back(nb);
            void'(sq.pop_front());
            w[i] = nb;
        end
        return w;
    endfunction

    // data driver and per-clock monitor
    always @(negedge clk) begin
        if (!rst) begin
            int ph;
            bit bad;
            ph = int'(phase_code);
            if (ph != prev_phase || start_seen) widx = 0;
            start_seen = 0;
            prev_phase = ph;
            rx_valid = gap_en ? cyc[0] : 1'b1;
            if (rx_valid) begin
                bad = (ph < good_lo) || (ph > good_hi)
                    || (hit_en && ph == hit_ph && widx == SETTLE + 2)
                    || (noise_en && widx < SETTLE);
                rx_data = next_word() ^ {{(DATA_W-1){1'b0}}, bad};
                widx++;
            end
            if (monitor_on && busy) begin
                // R2 phase stays inside the captured range
                check(ph >= cfg_first && ph <= cfg_last, "R2", "phase in range", ph, cfg_first);
            end
            if (monitor_on && done) begin
                // R6 done raised with busy low
                check(!busy, "R6", "busy at done", busy, 0);
            end
        end
    end

    task automatic run_scan(input int f, input int l, input int d,
                            input int glo, input int ghi, input bit mid_start,
                            input int exp_w, input bit chk_cycles, input string tag);
        int steps, dw, n;
        bit got;
        good_lo = glo; good_hi = ghi;
        first_code = PHASE_W'(f); last_code = PHASE_W'(l); dwell_words = DWELL_W'(d);
        cfg_first = f; cfg_last = (l > f) ? l : f;
        steps = cfg_last - cfg_first + 1;
        dw = (d == 0) ? 1 : d;
        @(negedge clk);
        start = 1'b1; start_seen = 1;
        @(negedge clk);
        start = 1'b0;
        monitor_on = 1;
        // R7 results cleared by start
        check(eye_width == 0 && !eye_closed, "R7", {tag, " cleared at start"}, eye_width, 0);
        n = 0; got = 0;
        while (n < 6000) begin
            @(negedge clk);
            n++;
            if (mid_start && (n == 10 || n == 40)) begin
                // R8 disturb inputs while busy
                start = 1'b1;
                first_code = '0; last_code = '1; dwell_words = 8'd1;
            end else begin
                start = 1'b0;
            end
            if (done) begin got = 1; break; end
        end
        start = 1'b0;
        monitor_on = 0;
        check(got, "R6", {tag, " done seen"}, got, 1);
        // R7 width and closed flag
        check(eye_width == exp_w, "R7", {tag, " width"}, eye_width, exp_w);
        check(eye_closed == (exp_w == 0), "R7", {tag, " closed"}, eye_closed, exp_w == 0);
        if (chk_cycles)
            // R6 cycles per step = SETTLE + dwell + 2
            check(n == steps * (SETTLE + dw + 2), "R6", {tag, " scan length"}, n,
                  steps * (SETTLE + dw + 2));
        @(negedge clk);
        // R6 one-cycle done
        check(!done, "R6", {tag, " done pulse width"}, done, 0);
        repeat (4) @(negedge clk);
        first_code = 5'd1;
        // R7 hold until next start, R2 phase stays put while idle
        check(eye_width == exp_w, "R7", {tag, " width held"}, eye_width, exp_w);
        check(phase_code == PHASE_W'(cfg_last), "R2", {tag, " idle phase"}, phase_code, cfg_last);
    endtask

    initial begin
        for (int i = 0; i < 7; i++) sq.push_back(1'b1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(!busy && !done, "R1", "busy/done after reset", {busy, done}, 0);
        check(eye_width == 0 && !eye_closed, "R1", "result after reset", eye_width, 0);
        check(phase_code == 0, "R1", "phase after reset", phase_code, 0);

        // R4 R5 main scan, eye open at 9..14
        run_scan(4, 20, 6, 9, 14, 0, 6, 1, "R4 open eye");
        // R7 closed eye
        run_scan(0, 7, 3, 31, 0, 0, 0, 1, "R7 closed eye");
        // R5 single bad bit inside the eye removes one step
        hit_en = 1; hit_ph = 6;
        run_scan(0, 12, 4, 2, 10, 0, 8, 1, "R5 single hit");
        hit_en = 0;
        // R5 gaps in valid
        gap_en = 1;
        run_scan(3, 9, 5, 5, 7, 0, 3, 0, "R5 valid gaps");
        gap_en = 0;
        // R5 dwell of 0 acts as 1
        run_scan(10, 12, 0, 0, 31, 0, 3, 1, "R5 dwell zero");
        // R2 reversed range -> single step
        run_scan(8, 2, 4, 8, 8, 0, 1, 1, "R2 reversed range");
        // R8 start and config changes ignored while busy
        run_scan(4, 20, 6, 9, 14, 1, 6, 1, "R8 busy start");
        // R3 corrupted words during settle ignored
        noise_en = 1;
        run_scan(1, 5, 4, 0, 31, 0, 5, 1, "R3 settle noise");
        noise_en = 0;
        // R7 full range width reaches 2^PHASE_W
        run_scan(0, 31, 2, 0, 31, 0, 32, 1, "R7 full range");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule